// File: doc/BRIEF.md
# Speculative Prefetch Path Walker

A control-flow change starts a walk. This can be a branch instruction or any other redirect of the program flow. During the walk the block predicts which cache lines the fetch unit will prefetch next along the speculative path. The walk starts at the line that holds the redirect target. Each following line is found in one of two ways. If no known branch sits in the current line, the walker steps to the next 64-byte line. If a small internal table records a discovered branch whose source is the current line, the walker jumps to that branch's recorded target line. The walk stops after exactly `K` lines.

For each line on the path, the walker sends a probe address to the cache model during the same cycle. It receives a presence answer in that cycle. A line that is already present is not prefetched, but it still counts as one of the `K` lines. A line that is missing is issued as a prefetch request. The branch table is filled through a separate write port.

The walker guards against loops. A recorded target may point at a line already visited in the current walk. In that case the walker steps sequentially instead, so the path cannot circle forever.

Top module: `spec_walker`

## Requirements
- R1: One cycle after `redir_valid` is sampled high, `busy` and `probe_valid` are high and `probe_addr` equals `redir_addr` with its low 6 bits cleared.
- R2: A walk probes exactly `K` lines, one per clock cycle. `busy` falls in the cycle after the `K`-th line.
- R3: If the current line matches no valid table entry, the next probed line is the current line plus 64.
- R4: If the current line matches a valid table entry's source, the next probed line is that entry's target. The sequential line after the branch is not probed (no bad-path line).
- R5: During a walk, a probed line with `probe_hit` high raises no prefetch, yet it still counts toward `K`. A line with `probe_hit` low raises `pf_valid` with `pf_addr` equal to `probe_addr`.
- R6: A redirect that arrives while a walk is busy discards the current walk. The next cycle begins a new walk of `K` lines at the new target.
- R7: A recorded target may equal the current line or any line already probed in the current walk. In that case the walker steps sequentially by 64 instead.
- R8: The branch table holds 16 entries. Each write stores the source and target with the low 6 bits cleared. Writes fill the entries in round-robin order, so the 17th write replaces the oldest entry.
- R9: After reset, and whenever no walk is running, `busy`, `probe_valid` and `pf_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Start a walk (branch or program-flow redirect) |
| redir_addr | input | ADDR_W | Redirect target address |
| tbl_wr | input | 1 | Write one discovered branch into the table |
| tbl_src | input | ADDR_W | Address inside the branch's source line |
| tbl_tgt | input | ADDR_W | Address inside the branch's target line |
| probe_hit | input | 1 | Probed line is already present (same cycle) |
| probe_valid | output | 1 | Probe address is valid |
| probe_addr | output | ADDR_W | Line address being probed |
| pf_valid | output | 1 | Prefetch request for the probed line |
| pf_addr | output | ADDR_W | Line address to prefetch |
| busy | output | 1 | Walk in progress |

## Verification
Wrong internal state shows up as a wrong line address on `probe_addr` in the very cycle the walker reaches it. Three faults produce this:
- a bad line counter,
- a table lookup that matches the wrong entry,
- a visited-line check that fails to trip.

A stale or missed table entry shows up one line after the branch line. There the bench sees the sequential line instead of the target, or the reverse. A counter fault surfaces at the end of the walk as a `busy` pulse that is one cycle too long or too short. A broken restart shows up in the first cycle after the new redirect.

// File: rtl/spec_walker.sv
module spec_walker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int K          = 4,
  parameter int TBL_N      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_src,
  input  logic [ADDR_W-1:0] tbl_tgt,
  input  logic              probe_hit,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              busy
);
  localparam int CNT_W = $clog2(K + 1);
  localparam int PTR_W = (TBL_N > 1) ? $clog2(TBL_N) : 1;
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(1) << LINE_SHIFT;

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
  endfunction

  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] vis_q [K];

  logic              tv_q   [TBL_N];
  logic [ADDR_W-1:0] tsrc_q [TBL_N];
  logic [ADDR_W-1:0] ttgt_q [TBL_N];
  logic [PTR_W-1:0]  wptr_q;

  logic              br_hit, seen;
  logic [ADDR_W-1:0] br_tgt, next_line;

  always_comb begin
    br_hit = 1'b0;
    br_tgt = '0;
    for (int i = TBL_N - 1; i >= 0; i--)
      if (tv_q[i] && tsrc_q[i] == cur_q) begin
        br_hit = 1'b1;
        br_tgt = ttgt_q[i];
      end
    seen = (br_tgt == cur_q);
    for (int i = 0; i < K; i++)
      if (CNT_W'(i) < cnt_q && vis_q[i] == br_tgt) seen = 1'b1;
    next_line = (br_hit && !seen) ? br_tgt : cur_q + LINE_STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      cnt_q  <= '0;
    end else if (redir_valid) begin
      busy_q <= 1'b1;
      cur_q  <= line_of(redir_addr);
      cnt_q  <= '0;
    end else if (busy_q) begin
      cur_q <= next_line;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(K - 1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < K; i++)
      if (busy_q && !redir_valid && cnt_q == CNT_W'(i)) vis_q[i] <= cur_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      for (int i = 0; i < TBL_N; i++) tv_q[i] <= 1'b0;
    end else if (tbl_wr) begin
      tv_q[wptr_q]   <= 1'b1;
      tsrc_q[wptr_q] <= line_of(tbl_src);
      ttgt_q[wptr_q] <= line_of(tbl_tgt);
      wptr_q <= (wptr_q == PTR_W'(TBL_N - 1)) ? '0 : wptr_q + 1'b1;
    end
  end

  assign busy        = busy_q;
  assign probe_valid = busy_q;
  assign probe_addr  = cur_q;
  assign pf_valid    = busy_q & ~probe_hit;
  assign pf_addr     = cur_q;
endmodule

// File: rtl/spec_walker_chk.sv
module spec_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int K          = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              probe_hit,
  input logic              probe_valid,
  input logic [ADDR_W-1:0] probe_addr,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              busy
);
  localparam int N_W = $clog2(K + 1) + 1;
  logic [N_W-1:0] n_q;

  always_ff @(posedge clk) begin
    if (!rst_n || redir_valid) n_q <= '0;
    else if (probe_valid) n_q <= n_q + 1'b1;
  end

  AST_START_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> busy && probe_valid &&
      probe_addr == {$past(redir_addr[ADDR_W-1:LINE_SHIFT]), {LINE_SHIFT{1'b0}}}); // R1
  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> n_q < N_W'(K)); // R2
  AST_WALK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> n_q == N_W'(K)); // R2
  AST_HIT_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_hit) |-> !pf_valid); // R5
  AST_MISS_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !probe_hit) |-> pf_valid && pf_addr == probe_addr); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !probe_valid && !pf_valid); // R9
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> probe_addr[LINE_SHIFT-1:0] == '0); // R8
endmodule

bind spec_walker spec_walker_chk #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
  .probe_hit(probe_hit), .probe_valid(probe_valid), .probe_addr(probe_addr),
  .pf_valid(pf_valid), .pf_addr(pf_addr), .busy(busy)
);

// File: tb/spec_walker_tb.sv
module spec_walker_tb;
  localparam int K = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_addr = '0;
  logic        tbl_wr = 1'b0;
  logic [31:0] tbl_src = '0, tbl_tgt = '0;
  logic        probe_hit = 1'b0;
  logic        probe_valid, pf_valid, busy;
  logic [31:0] probe_addr, pf_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spec_walker #(.K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .tbl_wr(tbl_wr), .tbl_src(tbl_src), .tbl_tgt(tbl_tgt), .probe_hit(probe_hit),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .busy(busy)
  );

  localparam int NV = 4;
  localparam logic [31:0] V_START [NV] = '{32'h1000, 32'h2010, 32'h8040, 32'h3000};
  localparam logic [5:0]  V_HIT   [NV] = '{6'b000000, 6'b101001, 6'b010010, 6'b111111};
  localparam logic [31:0] V_LINE  [NV][K] = '{
    '{32'h1000, 32'h1040, 32'h8000, 32'h8040, 32'h8080, 32'h80C0},
    '{32'h2000, 32'h2040, 32'h2080, 32'h20C0, 32'h2100, 32'h2140},
    '{32'h8040, 32'h1040, 32'h8000, 32'h8040, 32'h8080, 32'h80C0},
    '{32'h3000, 32'h3040, 32'h3080, 32'h30C0, 32'h3100, 32'h3140}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_branch(input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_src = s; tbl_tgt = t;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic start(input logic [31:0] a);
    @(negedge clk);
    redir_valid = 1'b1; redir_addr = a;
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !probe_valid && !pf_valid, "R9 reset idle", {29'd0, busy, probe_valid, pf_valid}, 32'h0);
    rst_n = 1'b1;

    wr_branch(32'h1050, 32'h8004);   // R8 unaligned write, line 1040 -> 8000
    wr_branch(32'h8040, 32'h1040);
    wr_branch(32'h3000, 32'h3000);   // self target, R7

    for (int v = 0; v < NV; v++) begin
      start(V_START[v]);
      for (int i = 0; i < K; i++) begin
        probe_hit = V_HIT[v][i];
        #1;
        chk(busy && probe_valid, "R1/R2 busy during walk", {31'd0, busy}, 32'h1);
        chk(probe_addr == V_LINE[v][i], "R3/R4/R7 probed line", probe_addr, V_LINE[v][i]);
        chk(pf_valid == !V_HIT[v][i], "R5 prefetch only on miss", {31'd0, pf_valid}, {31'd0, !V_HIT[v][i]});
        if (pf_valid) chk(pf_addr == V_LINE[v][i], "R5 prefetch address", pf_addr, V_LINE[v][i]);
        @(negedge clk);
      end
      probe_hit = 1'b0;
      #1;
      chk(!busy && !probe_valid && !pf_valid, "R2/R9 walk ends after K lines", {31'd0, busy}, 32'h0);
    end

    // R6 restart mid-walk
    start(32'h2000);
    @(negedge clk);
    redir_valid = 1'b1; redir_addr = 32'h5008;
    #1;
    chk(probe_addr == 32'h2040, "R6 old walk line before restart", probe_addr, 32'h2040);
    @(negedge clk);
    redir_valid = 1'b0;
    for (int i = 0; i < K; i++) begin
      #1;
      chk(busy && probe_addr == 32'h5000 + 32'(i) * 32'h40, "R6 restarted walk", probe_addr, 32'h5000 + 32'(i) * 32'h40);
      @(negedge clk);
    end
    #1;
    chk(!busy, "R6 restarted walk length", {31'd0, busy}, 32'h0);

    // R8 round-robin replacement: 16 more writes evict the three originals
    for (int i = 0; i < 16; i++) wr_branch(32'h000F_0000 + 32'(i) * 32'h40, 32'h000E_0000);
    start(32'h1000);
    @(negedge clk);
    #1;
    chk(probe_addr == 32'h1040, "R8 second line", probe_addr, 32'h1040);
    @(negedge clk);
    #1;
    chk(probe_addr == 32'h1080, "R8 evicted branch no longer followed", probe_addr, 32'h1080);
    repeat (K) @(negedge clk);

    // R4 newest entries still active
    start(32'h000F_03C0);
    @(negedge clk);
    #1;
    chk(probe_addr == 32'h000E_0000, "R4 recorded target followed", probe_addr, 32'h000E_0000);
    repeat (K) @(negedge clk);
    #1;
    chk(!busy && !pf_valid, "R9 idle after walk", {31'd0, busy}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule